// File: doc/BRIEF.md
# Same-Sign Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point words that carry the same sign and returns the packed 32-bit sum. Each word holds a sign bit in bit 31, an 8-bit biased exponent in bits 30:23 (bias 127) and a 23-bit fraction in bits 22:0. A nonzero operand is taken as a normal number whose mantissa is the fraction with a leading 1 restored. A word whose bits 30:0 are all zero is a zero.

Work starts with a one-cycle `start` pulse while the unit is idle. The operation then runs through four clocked steps. The first captures the operands. The second restores the hidden bits, selects the operand with the larger exponent and shifts the other mantissa right by the exponent difference, keeping guard, round and sticky bits. The third adds the mantissas and applies a single right normalisation when the sum carries out. The fourth rounds to nearest with ties to even, saturates an exponent overflow to infinity and repacks the fields.

The result is held until the next operation completes. `done` flags completion for one cycle. Mixed-sign operands, subnormals, NaN and infinity inputs are outside its scope.

Top module: `fp32_same_sign_adder`

## Requirements
- R1: While reset is asserted, and after it is released, `result` is 0x00000000 and `done` is 0.
- R2: When `start` is sampled high while idle at clock edge E, `done` is 1 after edge E+3 and 0 after edges E+1, E+2 and E+4.
- R3: For normal same-sign operands, the result is the packed, correctly rounded sum: sign in bit 31, biased exponent in bits 30:23, fraction in bits 22:0. For example, 0x3FC00000 + 0x40500000 = 0x40980000.
- R4: The operand with the smaller exponent is aligned to the other before addition, so swapping opA and opB gives the same result.
- R5: When the mantissa sum carries out of the leading position, it is shifted right one place and the exponent rises by one. For example, 0x3FC00000 + 0x3FC00000 = 0x40400000.
- R6: Rounding is to nearest with ties to even. 0x3F800000 + 0x33800000 = 0x3F800000, and 0x3F800001 + 0x33800000 = 0x3F800002.
- R7: With an exponent difference of 25 or more, the result equals the larger operand. With a difference of exactly 24 and a smaller mantissa of 1.0, the result is a tie and rounds to even: 0x4B800000 + 0x3F800000 = 0x4B800000.
- R8: A biased result exponent of 255 or more gives infinity, which is the sign, exponent 0xFF and fraction 0. For example, 0x7F7FFFFF + 0x7F7FFFFF = 0x7F800000.
- R9: If exactly one operand is zero, the result is the other operand unchanged. If both are zero, the result is zero with a sign equal to the AND of the two signs.
- R10: When both operands are nonzero, the result sign is bit 31 of opA. For example, 0xBFC00000 + 0xC0500000 = 0xC0980000.
- R11: `result` does not change except on the edge that raises `done`.
- R12: A `start` that arrives while an operation is in progress is ignored, and the operands driven with it do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when idle |
| opA | input | 32 | First operand, sampled with start |
| opB | input | 32 | Second operand, sampled with start |
| result | output | 32 | Packed sum, held until the next completion |
| done | output | 1 | One-cycle completion flag |

## Verification
Both `result` and `done` are due on the third rising edge after the edge that samples `start`, and the unit accepts a new operation on the following edge. The bench drives inputs on falling edges. It reads `done` on the falling edges after E+1 and E+2, where it must be low. It reads `result` together with `done` on the falling edge after E+3, and it reads both again one falling edge later to confirm that `done` has dropped and `result` has held. Expected sums come from an integer model of exact alignment and round-to-nearest-even. That model is applied to a sweep of every exponent difference from 0 to 30 against several edge-case fraction patterns, and then to random operand pairs.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int EXT_W   = MANT_W + 3;
  localparam int WIDE_W  = MANT_W + EXT_W;
  localparam int SH_W    = $clog2(EXT_W + 1);
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef struct packed {
    logic load;
    logic align;
    logic addNorm;
    logic pack;
  } fpaStrobe_t;
endpackage

// File: rtl/fpa_ctrl.sv
module fpa_ctrl
  import fpa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output fpaStrobe_t strobe,
  output logic       done
);
  typedef enum logic [1:0] {IDLE, ALIGN, ADD, PACK} state_t;
  state_t state, stateNext;

  always_comb begin
    strobe.load    = start && (state == IDLE);
    strobe.align   = (state == ALIGN);
    strobe.addNorm = (state == ADD);
    strobe.pack    = (state == PACK);
  end

  always_comb begin
    case (state)
      IDLE:    stateNext = start ? ALIGN : IDLE;
      ALIGN:   stateNext = ADD;
      ADD:     stateNext = PACK;
      default: stateNext = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.pack;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.align, strobe.addNorm, strobe.pack})); // R12
  AST_DONE_SEQUENCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(strobe.addNorm, 2)); // R2
endmodule

// File: rtl/fpa_datapath.sv
module fpa_datapath
  import fpa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fpaStrobe_t        strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] rawA, rawB;
  logic [EXP_W-1:0]  bigExp;
  logic [MANT_W-1:0] bigMant;
  logic [EXT_W-1:0]  alignMant;
  logic [EXT_W-1:0]  normMant;
  logic [EXP_W:0]    normExp;

  // align step: pick larger exponent, shift the other with sticky
  logic [EXP_W-1:0]  expA, expB, bExpD, sExpD, diff;
  logic [MANT_W-1:0] bMantD, sMantD;
  logic [SH_W-1:0]   shAmt;
  logic [WIDE_W-1:0] wide;
  logic [EXT_W-1:0]  alignD;
  logic              aGe;

  always_comb begin
    expA   = rawA[WORD_W-2 -: EXP_W];
    expB   = rawB[WORD_W-2 -: EXP_W];
    aGe    = (expA >= expB);
    bExpD  = aGe ? expA : expB;
    sExpD  = aGe ? expB : expA;
    bMantD = {1'b1, aGe ? rawA[FRAC_W-1:0] : rawB[FRAC_W-1:0]};
    sMantD = {1'b1, aGe ? rawB[FRAC_W-1:0] : rawA[FRAC_W-1:0]};
    diff   = bExpD - sExpD;
    shAmt  = (diff > EXP_W'(EXT_W)) ? SH_W'(EXT_W) : SH_W'(diff);
    wide   = {sMantD, {EXT_W{1'b0}}} >> shAmt;
    alignD = {wide[WIDE_W-1 -: EXT_W-1], |wide[MANT_W:0]};
  end

  // add step: sum plus one right normalisation on carry out
  logic [EXT_W:0]   sum;
  logic [EXT_W-1:0] normMantD;
  logic [EXP_W:0]   normExpD;

  always_comb begin
    sum = {1'b0, bigMant, 3'b000} + {1'b0, alignMant};
    if (sum[EXT_W]) begin
      normMantD = {sum[EXT_W:2], sum[1] | sum[0]};
      normExpD  = {1'b0, bigExp} + 1'b1;
    end else begin
      normMantD = sum[EXT_W-1:0];
      normExpD  = {1'b0, bigExp};
    end
  end

  // pack step: round to nearest even, saturate, zero bypass
  logic              roundUp;
  logic [MANT_W:0]   rnd;
  logic [EXP_W:0]    expR;
  logic [FRAC_W-1:0] fracR;
  logic              zeroA, zeroB;
  logic [WORD_W-1:0] packD;

  always_comb begin
    roundUp = normMant[2] & (normMant[1] | normMant[0] | normMant[3]);
    rnd     = {1'b0, normMant[EXT_W-1:3]} + {{MANT_W{1'b0}}, roundUp};
    if (rnd[MANT_W]) begin
      expR  = normExp + 1'b1;
      fracR = rnd[MANT_W-1:1];
    end else begin
      expR  = normExp;
      fracR = rnd[FRAC_W-1:0];
    end
    zeroA = (rawA[WORD_W-2:0] == '0);
    zeroB = (rawB[WORD_W-2:0] == '0);
    if (zeroA && zeroB)
      packD = {rawA[WORD_W-1] & rawB[WORD_W-1], {(WORD_W-1){1'b0}}};
    else if (zeroA)
      packD = rawB;
    else if (zeroB)
      packD = rawA;
    else if (expR >= (EXP_W+1)'(EXP_MAX))
      packD = {rawA[WORD_W-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      packD = {rawA[WORD_W-1], expR[EXP_W-1:0], fracR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawA      <= '0;
      rawB      <= '0;
      bigExp    <= '0;
      bigMant   <= '0;
      alignMant <= '0;
      normMant  <= '0;
      normExp   <= '0;
      result    <= '0;
    end else begin
      if (strobe.load) begin
        rawA <= opA;
        rawB <= opB;
      end
      if (strobe.align) begin
        bigExp    <= bExpD;
        bigMant   <= bMantD;
        alignMant <= alignD;
      end
      if (strobe.addNorm) begin
        normMant <= normMantD;
        normExp  <= normExpD;
      end
      if (strobe.pack) result <= packD;
    end
  end

  AST_NORMALISED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addNorm |=> normMant[EXT_W-1]); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pack |=> $stable(result)); // R11
  AST_INF_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}}) |-> (result[FRAC_W-1:0] == '0)); // R8
  AST_OPS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.align || strobe.addNorm) |=> $stable(rawA) && $stable(rawB)); // R12
endmodule

// File: rtl/fp32_same_sign_adder.sv
module fp32_same_sign_adder
  import fpa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [31:0] result,
  output logic        done
);
  fpaStrobe_t strobe;

  fpa_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  fpa_datapath uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );
endmodule

// File: tb/sim_fp32_same_sign_adder.sv
`timescale 1ns/1ps
module sim_fp32_same_sign_adder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [31:0] result;
  logic        done;
  int nChecks = 0, nFail = 0;

  fp32_same_sign_adder u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .opA(opA), .opB(opB), .result(result), .done(done)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] refAdd(input logic [31:0] a, input logic [31:0] b);
    int ea, eb, d, p, sh, e, t;
    longint unsigned ma, mb, s, m, rem, half, tm;
    logic [31:0] big;
    if (a[30:0] == 0 && b[30:0] == 0) return {a[31] & b[31], 31'b0};
    if (a[30:0] == 0) return b;
    if (b[30:0] == 0) return a;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    ma = {40'd1, a[22:0]}; mb = {40'd1, b[22:0]};
    big = a;
    if (ea < eb) begin
      t = ea; ea = eb; eb = t;
      tm = ma; ma = mb; mb = tm;
      big = b;
    end
    d = ea - eb;
    if (d > 30) return {a[31], big[30:0]};
    s = (ma << d) + mb;
    p = 0;
    for (int i = 0; i < 64; i++) if (s[i]) p = i;
    sh = p - 23;
    e = eb + sh;
    m = s >> sh;
    rem = s - (m << sh);
    half = (sh > 0) ? (64'd1 << (sh - 1)) : 64'd0;
    if (sh > 0 && (rem > half || (rem == half && m[0]))) m = m + 1;
    if (m == (64'd1 << 24)) begin m = m >> 1; e = e + 1; end
    if (e >= 255) return {a[31], 8'hFF, 23'b0};
    return {a[31], e[7:0], m[22:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start sampled at edge E; result and done read after E+3
  task automatic runOp(input logic [31:0] a, input logic [31:0] b, output logic [31:0] res,
                       output logic early, output logic dn);
    @(negedge clk); opA = a; opB = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); early = done;
    @(negedge clk); early = early | done;
    @(negedge clk); dn = done; res = result;
  endtask

  task automatic opCheck(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp);
    logic [31:0] r; logic e, d;
    runOp(a, b, r, e, d);
    check(req, r, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] r, r2, held;
    logic e, d;
    logic [22:0] pats [5];
    pats[0] = 23'h000000; pats[1] = 23'h7FFFFF; pats[2] = 23'h400000;
    pats[3] = 23'h000001; pats[4] = 23'h2AAAAA;

    repeat (3) @(negedge clk);
    check("R1 reset result", result, 32'h0);
    check("R1 reset done", {31'b0, done}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release result", result, 32'h0);
    check("R1 after release done", {31'b0, done}, 32'h0);

    // R2 timing with R3 example
    runOp(32'h3FC00000, 32'h40500000, r, e, d);
    check("R2 done low early", {31'b0, e}, 32'h0);
    check("R2 done high at E+3", {31'b0, d}, 32'h1);
    check("R3 example sum", r, 32'h40980000);
    held = result;
    @(negedge clk);
    check("R2 done low at E+4", {31'b0, done}, 32'h0);
    check("R11 result held", result, held);

    opCheck("R5 carry normalise", 32'h3FC00000, 32'h3FC00000, 32'h40400000);
    opCheck("R6 tie to even down", 32'h3F800000, 32'h33800000, 32'h3F800000);
    opCheck("R6 tie to even up", 32'h3F800001, 32'h33800000, 32'h3F800002);
    opCheck("R7 diff 24 tie", 32'h4B800000, 32'h3F800000, 32'h4B800000);
    opCheck("R7 diff 25", 32'h4C000000, 32'h3F800000, 32'h4C000000);
    opCheck("R7 diff large", 32'h3F800000, 32'h7F000000, 32'h7F000000);
    opCheck("R8 overflow inf", 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000);
    opCheck("R8 negative overflow", 32'hFF000000, 32'hFF000000, 32'hFF800000);
    opCheck("R9 zero left", 32'h00000000, 32'h40490FDB, 32'h40490FDB);
    opCheck("R9 zero right", 32'hC1200000, 32'h80000000, 32'hC1200000);
    opCheck("R9 both negative zero", 32'h80000000, 32'h80000000, 32'h80000000);
    opCheck("R9 mixed zeros", 32'h80000000, 32'h00000000, 32'h00000000);
    opCheck("R10 negative sum", 32'hBFC00000, 32'hC0500000, 32'hC0980000);

    // R12: start held while busy with other operands
    @(negedge clk); opA = 32'h3FC00000; opB = 32'h40500000; start = 1'b1;
    @(negedge clk); opA = 32'h7F000000; opB = 32'h7F000000;
    @(negedge clk);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check("R12 busy start ignored", result, 32'h40980000);
    check("R12 done once", {31'b0, done}, 32'h1);
    held = result;
    @(negedge clk);
    check("R11 held after busy test", result, held);
    check("R12 no second op", {31'b0, done}, 32'h0);

    // R4 sweep: every exponent difference against fraction patterns
    for (int dd = 0; dd <= 30; dd++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          logic [31:0] a, b;
          a = {1'b0, 8'(120 + dd), pats[i]};
          b = {1'b0, 8'd120, pats[j]};
          runOp(a, b, r, e, d);
          check("R4 sweep a+b", r, refAdd(a, b));
          if (i == j) begin
            runOp(b, a, r2, e, d);
            check("R4 swapped order", r2, r);
          end
        end

    // R3 random same-sign normals, plus R2 timing each time
    for (int k = 0; k < 2500; k++) begin
      logic [31:0] a, b;
      int ea, eb;
      logic s;
      s = 1'($urandom);
      ea = 1 + int'($urandom % 254);
      eb = ea - int'($urandom % 32);
      if (k % 4 == 0) eb = 1 + int'($urandom % 254);
      if (eb < 1) eb = 1;
      a = {s, 8'(ea), 23'($urandom)};
      b = {s, 8'(eb), 23'($urandom)};
      runOp(a, b, r, e, d);
      check("R3 random sum", r, refAdd(a, b));
      check("R2 random done", {30'b0, e, d}, 32'h1);
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule